// File: doc/BRIEF.md
# Contactless Frame Exchange Buffer

This block holds one frame for a contactless reader. The host loads a request through a sequential byte port: the first byte gives the request length, and the payload bytes follow. On a go strobe the block sends the payload to an RF transmit engine one byte at a time, then two CRC bytes it computes itself. After the last CRC byte it zeroes the whole buffer and waits for the answer.

The receive engine delivers decoded answer bytes, followed by an end-of-frame pulse. The block treats the last two bytes of the answer as its CRC and checks them. It never stores them. If the check passes, the answer data lands at byte 1 onward and byte 0 holds the count. If the check fails or the frame is malformed, byte 0 holds FFh and the data bytes are dropped. If no byte arrives within a parameterised number of cycles, byte 0 stays 00h. The host then reads the frame back through the same sequential port, starting at byte 0.

Top module: `cfx_buffer`

## Requirements
- R1: The buffer has 36 bytes and all of them are zero after reset. `host_start` sets the access pointer to 0. Each accepted write or read moves the pointer up by one and stops at 35. Read data appears on `host_rd_data` one cycle after `host_rd_en`.
- R2: A `host_go` in idle, with byte 0 in the range 1..35, starts an exchange. Bytes 1..len go out in order on `tx_data`, and each byte is taken when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` is held.
- R3: Right after the payload, two bytes carry the CRC, low byte first. The CRC uses the reflected form of polynomial 0x1021 (0x8408), starts at FFFFh, is fed LSB first, and is inverted at the end.
- R4: When the last CRC byte is accepted, all 36 bytes become 00h.
- R5: An answer ends with `rx_end`. The last two bytes received are its CRC, in the same format as R3. If they match, the bytes before them are stored from byte 1 onward, byte 0 holds their count, and the CRC bytes are not stored.
- R6: If no `rx_valid` arrives within ANS_TIMEOUT cycles after the last CRC byte is accepted, the exchange ends with `busy` low exactly ANS_TIMEOUT cycles after that acceptance, and byte 0 reads 00h.
- R7: Three cases give byte 0 = FFh with bytes 1..35 all zero: a CRC mismatch, an answer of fewer than two bytes, or more than 35 data bytes.
- R8: `busy` is high from an accepted go until the exchange ends. While `busy` is high, host writes have no effect and `tx_valid` is only high during transmit.
- R9: A go with byte 0 equal to 0 or above 35 is rejected. Nothing is transmitted and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_start | input | 1 | Set the access pointer to byte 0 |
| host_wr_en | input | 1 | Write `host_wr_data` at the pointer |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Read the byte at the pointer |
| host_rd_data | output | 8 | Registered read byte |
| host_go | input | 1 | Start an exchange |
| busy | output | 1 | Exchange in progress |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit engine takes the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End of the received frame |

## Verification
The assertions assume three things about the inputs. `rx_end` never comes in the same cycle as `rx_valid`. The host does not write while it issues a go. `tx_ready` may stall freely. The stimulus meets these by driving each strobe in its own cycle on the falling edge and by toggling `tx_ready` in a fixed pattern during the payload sweep. The sweep covers every request length from 1 to 35, each paired with a different answer length, so the bench can compute every transmitted CRC and every stored byte independently.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_WAIT,
        ST_RECV
    } cfx_state_e;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
endpackage

// File: rtl/cfx_crc.sv
module cfx_crc
    import cfx_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        c = crc_in ^ {8'h00, data_in};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/cfx_frame_mem.sv
module cfx_frame_mem #(
    parameter int DEPTH = 36,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          clr_all,
    input  logic          clr_body,
    input  logic [AW-1:0] rd_idx_a,
    output logic [7:0]    rd_a,
    input  logic [AW-1:0] rd_idx_b,
    output logic [7:0]    rd_b,
    output logic [7:0]    head
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_idx == AW'(i)) mem[i] <= wr_data;
                else if (clr_all || (clr_body && i != 0)) mem[i] <= '0;
            end
        end
    end

    assign rd_a = (rd_idx_a <= AW'(DEPTH - 1)) ? mem[rd_idx_a] : 8'h00;
    assign rd_b = (rd_idx_b <= AW'(DEPTH - 1)) ? mem[rd_idx_b] : 8'h00;
    assign head = mem[0];
endmodule

// File: rtl/cfx_buffer.sv
module cfx_buffer
    import cfx_pkg::*;
#(
    parameter int FRAME_BYTES = 36,
    parameter int ANS_TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_start,
    input  logic       host_wr_en,
    input  logic [7:0] host_wr_data,
    input  logic       host_rd_en,
    output logic [7:0] host_rd_data,
    input  logic       host_go,
    output logic       busy,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_end
);
    localparam int MAX_PAYLOAD = FRAME_BYTES - 1;
    localparam int AW = $clog2(FRAME_BYTES);
    localparam int TW = $clog2(ANS_TIMEOUT + 1);

    typedef struct packed {
        cfx_state_e    st;
        logic [AW-1:0] ptr;
        logic [7:0]    rd;
        logic [AW-1:0] idx;
        logic [15:0]   crc;
        logic [TW-1:0] tmo;
        logic [7:0]    h0;
        logic [7:0]    h1;
        logic [1:0]    nh;
        logic [AW-1:0] cnt;
        logic          ovf;
    } regs_t;

    regs_t q, d;

    logic          m_wr_en, m_clr_all, m_clr_body;
    logic [AW-1:0] m_wr_idx;
    logic [7:0]    m_wr_data, host_byte, tx_byte, len_byte;
    logic [7:0]    crc_byte;
    logic [15:0]   crc_next;
    logic          len_ok, crc_match;

    cfx_frame_mem #(.DEPTH(FRAME_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(m_wr_en), .wr_idx(m_wr_idx), .wr_data(m_wr_data),
        .clr_all(m_clr_all), .clr_body(m_clr_body),
        .rd_idx_a(q.ptr), .rd_a(host_byte),
        .rd_idx_b(q.idx), .rd_b(tx_byte),
        .head(len_byte)
    );

    assign crc_byte = (q.st == ST_SEND) ? tx_byte : q.h0;

    cfx_crc u_crc (.crc_in(q.crc), .data_in(crc_byte), .crc_out(crc_next));

    assign len_ok    = (len_byte != 8'h00) && (len_byte <= 8'(MAX_PAYLOAD));
    assign crc_match = ({q.h1, q.h0} == ~q.crc);
    assign busy      = (q.st != ST_IDLE);
    assign host_rd_data = q.rd;

    always_comb begin
        d          = q;
        m_wr_en    = 1'b0;
        m_wr_idx   = '0;
        m_wr_data  = '0;
        m_clr_all  = 1'b0;
        m_clr_body = 1'b0;
        tx_valid   = 1'b0;
        tx_data    = 8'h00;

        // host port
        if (host_start) begin
            d.ptr = '0;
        end else if ((host_wr_en && q.st == ST_IDLE) || host_rd_en) begin
            if (host_wr_en && q.st == ST_IDLE) begin
                m_wr_en   = 1'b1;
                m_wr_idx  = q.ptr;
                m_wr_data = host_wr_data;
            end else begin
                d.rd = host_byte;
            end
            if (q.ptr != AW'(FRAME_BYTES - 1)) d.ptr = q.ptr + AW'(1);
        end

        case (q.st)
            ST_IDLE: begin
                if (host_go && len_ok) begin
                    d.st  = ST_SEND;
                    d.idx = AW'(1);
                    d.crc = CRC_SEED;
                end
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_data  = tx_byte;
                if (tx_ready) begin
                    d.crc = crc_next;
                    if (8'(q.idx) == len_byte) d.st = ST_CRC_LO;
                    else d.idx = q.idx + AW'(1);
                end
            end
            ST_CRC_LO: begin
                tx_valid = 1'b1;
                tx_data  = ~q.crc[7:0];
                if (tx_ready) d.st = ST_CRC_HI;
            end
            ST_CRC_HI: begin
                tx_valid = 1'b1;
                tx_data  = ~q.crc[15:8];
                if (tx_ready) begin
                    d.st      = ST_WAIT;
                    m_clr_all = 1'b1;
                    d.tmo     = '0;
                    d.nh      = '0;
                    d.cnt     = '0;
                    d.ovf     = 1'b0;
                    d.crc     = CRC_SEED;
                end
            end
            ST_WAIT: begin
                if (rx_valid) begin
                    d.st = ST_RECV;
                    d.h0 = q.h1;
                    d.h1 = rx_data;
                    d.nh = 2'd1;
                end else if (q.tmo == TW'(ANS_TIMEOUT - 1)) begin
                    d.st = ST_IDLE;
                end else begin
                    d.tmo = q.tmo + TW'(1);
                end
            end
            ST_RECV: begin
                if (rx_end) begin
                    d.st    = ST_IDLE;
                    m_wr_en = 1'b1;
                    if (q.nh == 2'd2 && !q.ovf && crc_match) begin
                        m_wr_data = 8'(q.cnt);
                    end else begin
                        m_wr_data  = 8'hFF;
                        m_clr_body = 1'b1;
                    end
                end else if (rx_valid) begin
                    if (q.nh == 2'd2) begin
                        d.crc = crc_next;
                        if (q.cnt < AW'(MAX_PAYLOAD)) begin
                            m_wr_en   = 1'b1;
                            m_wr_idx  = q.cnt + AW'(1);
                            m_wr_data = q.h0;
                            d.cnt     = q.cnt + AW'(1);
                        end else begin
                            d.ovf = 1'b1;
                        end
                    end else begin
                        d.nh = q.nh + 2'd1;
                    end
                    d.h0 = q.h1;
                    d.h1 = rx_data;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, crc: CRC_SEED, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfx_checker.sv
module cfx_checker #(
    parameter int MAX_PAYLOAD = 35
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       host_go,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic [7:0] len_byte
);
    AST_GO_STARTS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_go && len_byte != 8'h00 && len_byte <= 8'(MAX_PAYLOAD)) |=> (busy && tx_valid)); // R2

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R2

    AST_CLEARED_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> (len_byte == 8'h00)); // R4

    AST_TX_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy); // R8

    AST_BAD_LEN_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_go && (len_byte == 8'h00 || len_byte > 8'(MAX_PAYLOAD))) |=> !busy); // R9
endmodule

bind cfx_buffer cfx_checker #(.MAX_PAYLOAD(FRAME_BYTES - 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .host_go(host_go),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .len_byte(len_byte)
);

// File: tb/cfx_buffer_test.sv
module cfx_buffer_test;
    localparam int T = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_start = 1'b0, host_wr_en = 1'b0, host_rd_en = 1'b0, host_go = 1'b0;
    logic [7:0] host_wr_data = 8'h00;
    logic [7:0] host_rd_data;
    logic       busy, tx_valid, tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0] rx_data = 8'h00;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] got [36];
    logic [7:0] req [36];
    logic [7:0] ans [40];

    always #5 clk = ~clk;

    cfx_buffer #(.FRAME_BYTES(36), .ANS_TIMEOUT(T)) uut (
        .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_wr_en(host_wr_en),
        .host_wr_data(host_wr_data), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .host_go(host_go), .busy(busy), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_b(input int n, input logic [7:0] b [40]);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ b[i][k];
                c = {1'b0, c[15:1]};
                if (fb) c = c ^ 16'h8408;
            end
        end
        return ~c;
    endfunction

    task automatic pulse_start();
        @(negedge clk); host_start = 1'b1;
        @(posedge clk); #1 host_start = 1'b0;
    endtask

    task automatic write_req(input int nbytes);
        pulse_start();
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk); host_wr_en = 1'b1; host_wr_data = req[i];
            @(posedge clk);
        end
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic read_all(input int n);
        pulse_start();
        for (int i = 0; i < n; i++) begin
            @(negedge clk); host_rd_en = 1'b1;
            @(posedge clk);
            @(negedge clk); got[i] = host_rd_data;
            host_rd_en = 1'b0;
        end
    endtask

    // go, collect payload + CRC, check them; returns just after last accept edge
    task automatic go_and_collect(input int len, input bit stall);
        logic [7:0] pl [40];
        logic [15:0] c;
        int n = 0, guard = 0;
        for (int i = 0; i < len; i++) pl[i] = req[i + 1];
        c = crc_b(len, pl);
        @(negedge clk); host_go = 1'b1;
        @(posedge clk);
        @(negedge clk); host_go = 1'b0;
        chk(busy === 1'b1, "R8 busy after go", busy, 1);
        while (n < len + 2 && guard < 400) begin
            guard++;
            if (guard > 1) @(negedge clk);
            tx_ready = stall ? (guard % 3 != 0) : 1'b1;
            #1;
            if (tx_valid && tx_ready) begin
                if (n < len) chk(tx_data === pl[n], "R2 payload byte", tx_data, pl[n]);
                else if (n == len) chk(tx_data === c[7:0], "R3 crc low", tx_data, c[7:0]);
                else chk(tx_data === c[15:8], "R3 crc high", tx_data, c[15:8]);
                n++;
            end
            @(posedge clk);
        end
        tx_ready = 1'b1;
        chk(n == len + 2, "R2 byte count sent", n, len + 2);
    endtask

    task automatic answer(input int n, input bit bad, input int extra_total);
        logic [15:0] c;
        int tot;
        c = crc_b(n, ans);
        ans[n] = c[7:0] ^ (bad ? 8'h01 : 8'h00);
        ans[n + 1] = c[15:8];
        tot = (extra_total >= 0) ? extra_total : n + 2;
        for (int i = 0; i < tot; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = ans[i];
            @(posedge clk);
        end
        @(negedge clk); rx_valid = 1'b0; rx_end = 1'b1;
        @(posedge clk);
        @(negedge clk); rx_end = 1'b0;
        chk(busy === 1'b0, "R8 idle after answer", busy, 0);
    endtask

    task automatic expect_frame(input logic [7:0] b0, input int n, input string tag);
        read_all(36);
        chk(got[0] === b0, tag, got[0], b0);
        for (int i = 1; i < 36; i++) begin
            logic [7:0] e;
            e = (i <= n) ? ans[i - 1] : 8'h00;
            chk(got[i] === e, tag, got[i], e);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk(busy === 1'b0, "R1 busy at reset", busy, 0);
        chk(tx_valid === 1'b0, "R1 tx_valid at reset", tx_valid, 0);
        read_all(36);
        for (int i = 0; i < 36; i++) chk(got[i] === 8'h00, "R1 zero after reset", got[i], 0);

        // R1 pointer saturation: 40 writes, 37 reads
        for (int i = 0; i < 36; i++) req[i] = 8'(i + 1);
        pulse_start();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); host_wr_en = 1'b1; host_wr_data = 8'(i + 1);
            @(posedge clk);
        end
        @(negedge clk); host_wr_en = 1'b0;
        read_all(36);
        for (int i = 0; i < 35; i++) chk(got[i] === 8'(i + 1), "R1 sequential store", got[i], i + 1);
        chk(got[35] === 8'd40, "R1 pointer stops at 35", got[35], 40);
        @(negedge clk); host_rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk); host_rd_en = 1'b0;
        chk(host_rd_data === 8'd40, "R1 read pointer saturates", host_rd_data, 40);

        // R9 rejected lengths
        foreach (req[i]) req[i] = 8'h00;
        for (int v = 0; v < 2; v++) begin
            req[0] = (v == 0) ? 8'd0 : 8'd36;
            write_req(1);
            @(negedge clk); host_go = 1'b1;
            @(posedge clk);
            @(negedge clk); host_go = 1'b0;
            for (int k = 0; k < 4; k++) begin
                chk(busy === 1'b0 && tx_valid === 1'b0, "R9 bad length rejected", {busy, tx_valid}, 0);
                @(negedge clk);
            end
        end

        // R2 R3 R4 R5 sweep of request lengths with varied answer lengths
        for (int L = 1; L <= 35; L++) begin
            int n;
            n = 36 - L;
            req[0] = 8'(L);
            for (int i = 1; i <= L; i++) req[i] = 8'((L * 7 + i * 13) & 8'hFF);
            write_req(L + 1);
            go_and_collect(L, (L % 2) == 1);
            for (int i = 0; i < n; i++) ans[i] = 8'((L * 11 + i * 29 + 3) & 8'hFF);
            answer(n, 1'b0, -1);
            expect_frame(8'(n), n, "R5 stored answer");
        end

        // R5 answer with no data bytes, only CRC
        req[0] = 8'd2; req[1] = 8'h05; req[2] = 8'h00;
        write_req(3);
        go_and_collect(2, 1'b0);
        answer(0, 1'b0, -1);
        expect_frame(8'h00, 0, "R5 empty answer");

        // R7 CRC mismatch
        write_req(3);
        go_and_collect(2, 1'b0);
        for (int i = 0; i < 10; i++) ans[i] = 8'(i * 17 + 1);
        answer(10, 1'b1, -1);
        expect_frame(8'hFF, 0, "R7 crc error");

        // R7 overlong answer: 36 data bytes
        write_req(3);
        go_and_collect(2, 1'b0);
        for (int i = 0; i < 36; i++) ans[i] = 8'(i + 100);
        answer(36, 1'b0, -1);
        expect_frame(8'hFF, 0, "R7 overflow");

        // R7 single-byte answer
        write_req(3);
        go_and_collect(2, 1'b0);
        ans[0] = 8'h5A;
        answer(0, 1'b0, 1);
        expect_frame(8'hFF, 0, "R7 short answer");

        // R6 timeout, R8 write while busy ignored
        req[0] = 8'd3; req[1] = 8'h11; req[2] = 8'h22; req[3] = 8'h33;
        write_req(4);
        go_and_collect(3, 1'b0);
        for (int k = 1; k < T; k++) begin
            @(negedge clk); host_wr_en = (k == 2); host_wr_data = 8'hAA;
            @(posedge clk);
        end
        @(negedge clk); host_wr_en = 1'b0;
        chk(busy === 1'b1, "R6 still waiting before timeout", busy, 1);
        @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0, "R6 idle at timeout", busy, 0);
        expect_frame(8'h00, 0, "R6 R8 no answer and ignored write");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule